// File: doc/BRIEF.md
# DMA Transfer Length Counter

This block sizes one DMA data transfer of a SCSI host adapter and follows it down to zero. When the transfer-information strobe arrives it takes the 16-bit programmed count and works out the effective length. That length is the smaller of the programmed count and the number of bytes the target still expects. In a command phase a fixed cap of 32 bytes replaces the target's count. The target count is a signed quantity: positive means data flows in from the target, negative means data flows out to it.

After the start, two handshakes drive the count. The target side announces a ready chunk with its size. The memory side reports each group of bytes it has moved. The block lowers the transfer count and the bytes left in the current chunk, and moves the signed target count toward zero. It then decides when the transfer is finished. Some completions fire at once; others wait for the next ready chunk. On completion it updates its status and interrupt bytes, clears the held count, and raises an interrupt request. A host acknowledge drops that request again.

Top module: `xfer_len_top`

## Requirements
- R1: A programmed count of 0 is taken as 65536 bytes (for example, programmed 0 with target count 70000 gives an effective length of 65536).
- R2: Outside a command phase, the effective length loaded into `xferLeft` is the smaller of the programmed count and the magnitude of the signed target count. The sign does not matter.
- R3: In a command phase, the effective length is the smaller of the programmed count and 32. The target count is not used.
- R4: A start strobe clears status bit 4 (mask 0x10) and copies `progLen` into `countReg`.
- R5: On completion, `statusReg` gains bits 7 and 4 (0x90), `intrReg` becomes 0x10, `countReg` becomes 0, `irq` goes high, and `xferDone` pulses for one cycle.
- R6: On a data-in transfer (`dirIn`=1), completion fires in the cycle after the move that empties both the count and the current chunk, provided the target count is still above zero after that move.
- R7: A data-out transfer that empties the count and the chunk, or a data-in transfer that leaves the target count at or below zero, does not complete. It completes in the cycle after the next ready chunk of nonzero size.
- R8: A move that brings the count to zero while bytes remain in the current chunk completes the transfer at once.
- R9: Each data-in move subtracts its byte count from `tgtRemain`. Each data-out move adds its byte count to `tgtRemain`.
- R10: A ready chunk or a move report with a byte count of zero changes no count and causes no completion.
- R11: `intAck` clears `irq` and status bit 7 and leaves status bit 4 unchanged.
- R12: After reset, `xferLeft`, `countReg`, `statusReg`, `intrReg`, `irq` and `xferDone` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| progLen | input | 16 | Programmed transfer count (0 means 65536) |
| xferStart | input | 1 | Transfer-information strobe |
| cmdPhase | input | 1 | Transfer belongs to a command phase (cap of 32) |
| dirIn | input | 1 | 1 = data in from the target, 0 = data out; sampled at start |
| tgtLoad | input | 1 | Loads the signed target byte count |
| tgtCount | input | 18 | Signed target byte count to load |
| chunkRdy | input | 1 | Target side announces a ready chunk |
| chunkLen | input | 17 | Size of the ready chunk in bytes |
| moveStb | input | 1 | Memory side reports moved bytes |
| moveBytes | input | 17 | Number of bytes moved |
| intAck | input | 1 | Host acknowledge of the interrupt |
| xferLeft | output | 17 | Bytes still to move in this transfer |
| tgtRemain | output | 18 | Signed target byte count |
| countReg | output | 16 | Held programmed count, cleared on completion |
| statusReg | output | 8 | Status byte (bit 7 interrupt, bit 4 terminal count) |
| intrReg | output | 8 | Interrupt cause byte |
| irq | output | 1 | Interrupt request |
| xferDone | output | 1 | One-cycle completion pulse |

## Verification
Every output comes from a register that updates on the clock edge after the strobe that causes it. The effective length, the cleared terminal-count bit and the held count are therefore due one cycle after the start strobe. The completion bytes and the `xferDone` pulse are due one cycle after the move or ready chunk that finishes the transfer. The bench drives each strobe for one cycle from a falling edge and samples at the next falling edge, which is exactly one rising edge later. In that same sample it checks that `xferDone` is high, because the pulse lasts only that one cycle. For deferred completions it also checks that nothing has fired in the cycles before the ready chunk arrives.

// File: rtl/xfer_len_pkg.sv
package xfer_len_pkg;
  // Strobes from the control FSM to the datapath.
  typedef struct packed {
    logic loadXfer;   // size a new transfer
    logic applyChunk; // take a new target chunk size
    logic applyMove;  // account for moved bytes
    logic finish;     // completion update
    logic ack;        // host acknowledge
  } ctlStrobes_t;
endpackage

// File: rtl/xfer_len_dp.sv
module xfer_len_dp
  import xfer_len_pkg::*;
#(
  parameter int LEN_W   = 16,
  parameter int CMD_CAP = 32
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  ctlStrobes_t             strb,
  input  logic [LEN_W-1:0]        progLen,
  input  logic                    cmdPhase,
  input  logic                    dirIn,
  input  logic                    tgtLoad,
  input  logic signed [LEN_W+1:0] tgtCount,
  input  logic [LEN_W:0]          chunkLen,
  input  logic [LEN_W:0]          moveBytes,
  output logic                    effZero,
  output logic                    leftZero,
  output logic                    postLeftZero,
  output logic                    postAvailZero,
  output logic                    postRemPos,
  output logic                    dirLat,
  output logic                    chunkNz,
  output logic                    moveNz,
  output logic [LEN_W:0]          xferLeft,
  output logic signed [LEN_W+1:0] tgtRemain,
  output logic [LEN_W-1:0]        countReg,
  output logic [7:0]              statusReg,
  output logic [7:0]              intrReg,
  output logic                    irq,
  output logic                    xferDone
);
  localparam int CNT_W = LEN_W + 1;
  localparam int REM_W = LEN_W + 2;
  localparam logic [CNT_W-1:0] FULL_LEN = CNT_W'(1) << LEN_W;
  localparam logic [REM_W-1:0] CAP_EXT  = REM_W'(CMD_CAP);
  localparam logic [7:0] ST_INT  = 8'h80;
  localparam logic [7:0] ST_TC   = 8'h10;
  localparam logic [7:0] INT_SVC = 8'h10;

  logic [CNT_W-1:0]        leftCnt, availCnt;
  logic signed [REM_W-1:0] remainCnt;
  logic [CNT_W-1:0]        progEff, effLen, leftNext, availNext;
  logic [REM_W-1:0]        remMag, limit;
  logic signed [REM_W-1:0] moveExt, remainNext;

  // Effective length: programmed count (0 -> full) clamped by the limit.
  always_comb begin
    progEff = (progLen == '0) ? FULL_LEN : {1'b0, progLen};
    remMag  = remainCnt[REM_W-1] ? REM_W'(-remainCnt) : REM_W'(remainCnt);
    limit   = cmdPhase ? CAP_EXT : remMag;
    effLen  = ({1'b0, progEff} <= limit) ? progEff : limit[CNT_W-1:0];
  end

  // Values after the current move report.
  always_comb begin
    moveExt    = $signed({1'b0, moveBytes});
    leftNext   = leftCnt - moveBytes;
    availNext  = availCnt - moveBytes;
    remainNext = dirLat ? (remainCnt - moveExt) : (remainCnt + moveExt);
  end

  assign effZero       = (effLen == '0);
  assign leftZero      = (leftCnt == '0);
  assign postLeftZero  = (leftNext == '0);
  assign postAvailZero = (availNext == '0);
  assign postRemPos    = !remainNext[REM_W-1] && (remainNext != '0);
  assign chunkNz       = (chunkLen != '0);
  assign moveNz        = (moveBytes != '0);

  // Count state.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      leftCnt   <= '0;
      availCnt  <= '0;
      remainCnt <= '0;
      dirLat    <= 1'b0;
    end else begin
      if (strb.loadXfer) begin
        leftCnt <= effLen;
        dirLat  <= dirIn;
      end else if (strb.applyMove) begin
        leftCnt <= leftNext;
      end
      if (strb.applyChunk)     availCnt <= chunkLen;
      else if (strb.applyMove) availCnt <= availNext;
      if (tgtLoad)             remainCnt <= tgtCount;
      else if (strb.applyMove) remainCnt <= remainNext;
    end
  end

  // Host-visible bytes and interrupt.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      countReg  <= '0;
      statusReg <= '0;
      intrReg   <= '0;
      irq       <= 1'b0;
      xferDone  <= 1'b0;
    end else begin
      xferDone <= strb.finish;
      if (strb.loadXfer) begin
        countReg  <= progLen;
        statusReg <= statusReg & ~ST_TC;
      end
      if (strb.ack) begin
        irq          <= 1'b0;
        statusReg[7] <= 1'b0;
      end
      if (strb.finish) begin
        statusReg <= statusReg | ST_INT | ST_TC;
        intrReg   <= INT_SVC;
        countReg  <= '0;
        irq       <= 1'b1;
      end
    end
  end

  assign xferLeft  = leftCnt;
  assign tgtRemain = remainCnt;

  assert_left_bound_R1: assert property (@(posedge clk) disable iff (!rstN)
    leftCnt <= FULL_LEN);

  assert_start_clears_tc_R4: assert property (@(posedge clk) disable iff (!rstN)
    strb.loadXfer |=> (!statusReg[4] && countReg == $past(progLen)));

  assert_done_flags_R5: assert property (@(posedge clk) disable iff (!rstN)
    xferDone |-> (irq && intrReg == INT_SVC && countReg == '0 && statusReg[7] && statusReg[4]));

  assert_ack_drops_irq_R11: assert property (@(posedge clk) disable iff (!rstN)
    (strb.ack && !strb.finish) |=> !irq);
endmodule

// File: rtl/xfer_len_ctl.sv
module xfer_len_ctl
  import xfer_len_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        xferStart,
  input  logic        chunkRdy,
  input  logic        moveStb,
  input  logic        intAck,
  input  logic        effZero,
  input  logic        leftZero,
  input  logic        postLeftZero,
  input  logic        postAvailZero,
  input  logic        postRemPos,
  input  logic        dirLat,
  input  logic        chunkNz,
  input  logic        moveNz,
  output ctlStrobes_t strb
);
  typedef enum logic [1:0] {ST_IDLE, ST_MOVE, ST_WAIT} ctlState_t;
  ctlState_t st, stNext;

  always_comb begin
    strb     = '0;
    strb.ack = intAck;
    stNext   = st;
    if (xferStart) begin
      strb.loadXfer = 1'b1;
      stNext        = effZero ? ST_WAIT : ST_MOVE;
    end else begin
      case (st)
        ST_MOVE: begin
          if (chunkRdy && chunkNz) begin
            strb.applyChunk = 1'b1;
          end else if (moveStb && moveNz) begin
            strb.applyMove = 1'b1;
            if (postLeftZero && !postAvailZero) begin
              strb.finish = 1'b1;      // chunk partly used
              stNext      = ST_IDLE;
            end else if (postLeftZero) begin
              if (dirLat && postRemPos) begin
                strb.finish = 1'b1;    // data-in, target has more
                stNext      = ST_IDLE;
              end else begin
                stNext = ST_WAIT;      // defer to next chunk
              end
            end
          end
        end
        ST_WAIT: begin
          if (chunkRdy && chunkNz) begin
            strb.applyChunk = 1'b1;
            strb.finish     = 1'b1;
            stNext          = ST_IDLE;
          end
        end
        default: stNext = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) st <= ST_IDLE;
    else       st <= stNext;
  end

  assert_wait_count_empty_R7: assert property (@(posedge clk) disable iff (!rstN)
    (st == ST_WAIT) |-> leftZero);

  assert_finish_only_busy_R5: assert property (@(posedge clk) disable iff (!rstN)
    strb.finish |-> (st != ST_IDLE));

  assert_zero_move_ignored_R10: assert property (@(posedge clk) disable iff (!rstN)
    (moveStb && !moveNz) |-> !strb.applyMove);
endmodule

// File: rtl/xfer_len_top.sv
module xfer_len_top
  import xfer_len_pkg::*;
#(
  parameter int LEN_W   = 16,
  parameter int CMD_CAP = 32
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic [LEN_W-1:0]        progLen,
  input  logic                    xferStart,
  input  logic                    cmdPhase,
  input  logic                    dirIn,
  input  logic                    tgtLoad,
  input  logic signed [LEN_W+1:0] tgtCount,
  input  logic                    chunkRdy,
  input  logic [LEN_W:0]          chunkLen,
  input  logic                    moveStb,
  input  logic [LEN_W:0]          moveBytes,
  input  logic                    intAck,
  output logic [LEN_W:0]          xferLeft,
  output logic signed [LEN_W+1:0] tgtRemain,
  output logic [LEN_W-1:0]        countReg,
  output logic [7:0]              statusReg,
  output logic [7:0]              intrReg,
  output logic                    irq,
  output logic                    xferDone
);
  ctlStrobes_t strb;
  logic effZero, leftZero, postLeftZero, postAvailZero, postRemPos;
  logic dirLat, chunkNz, moveNz;

  xfer_len_ctl u_ctl (
    .clk(clk), .rstN(rstN), .xferStart(xferStart), .chunkRdy(chunkRdy),
    .moveStb(moveStb), .intAck(intAck), .effZero(effZero), .leftZero(leftZero),
    .postLeftZero(postLeftZero), .postAvailZero(postAvailZero),
    .postRemPos(postRemPos), .dirLat(dirLat), .chunkNz(chunkNz),
    .moveNz(moveNz), .strb(strb)
  );

  xfer_len_dp #(.LEN_W(LEN_W), .CMD_CAP(CMD_CAP)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .progLen(progLen),
    .cmdPhase(cmdPhase), .dirIn(dirIn), .tgtLoad(tgtLoad), .tgtCount(tgtCount),
    .chunkLen(chunkLen), .moveBytes(moveBytes), .effZero(effZero),
    .leftZero(leftZero), .postLeftZero(postLeftZero),
    .postAvailZero(postAvailZero), .postRemPos(postRemPos), .dirLat(dirLat),
    .chunkNz(chunkNz), .moveNz(moveNz), .xferLeft(xferLeft),
    .tgtRemain(tgtRemain), .countReg(countReg), .statusReg(statusReg),
    .intrReg(intrReg), .irq(irq), .xferDone(xferDone)
  );
endmodule

// File: tb/sim_xfer_len_top.sv
module sim_xfer_len_top;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [15:0] progLen = '0;
  logic xferStart = 1'b0, cmdPhase = 1'b0, dirIn = 1'b0, tgtLoad = 1'b0;
  logic signed [17:0] tgtCount = '0;
  logic chunkRdy = 1'b0, moveStb = 1'b0, intAck = 1'b0;
  logic [16:0] chunkLen = '0, moveBytes = '0;
  logic [16:0] xferLeft;
  logic signed [17:0] tgtRemain;
  logic [15:0] countReg;
  logic [7:0] statusReg, intrReg;
  logic irq, xferDone;

  int nChecks = 0;
  int nFails  = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk; // 250 MHz

  xfer_len_top u0 (
    .clk(clk), .rstN(rstN), .progLen(progLen), .xferStart(xferStart),
    .cmdPhase(cmdPhase), .dirIn(dirIn), .tgtLoad(tgtLoad), .tgtCount(tgtCount),
    .chunkRdy(chunkRdy), .chunkLen(chunkLen), .moveStb(moveStb),
    .moveBytes(moveBytes), .intAck(intAck), .xferLeft(xferLeft),
    .tgtRemain(tgtRemain), .countReg(countReg), .statusReg(statusReg),
    .intrReg(intrReg), .irq(irq), .xferDone(xferDone)
  );

  // Vector table: programmed count, target count, command phase, expected length.
  localparam int NV = 8;
  localparam logic [15:0] V_PROG [NV] = '{16'd100, 16'd500, 16'd0, 16'd0, 16'd50, 16'd100, 16'd10, 16'd0};
  localparam int          V_TGT  [NV] = '{300, 200, 70000, -1000, -20, 300, 0, 0};
  localparam bit          V_CMD  [NV] = '{1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1};
  localparam int          V_EXP  [NV] = '{100, 200, 65536, 1000, 20, 32, 10, 32};

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Each task is entered on a falling edge and returns one cycle later.
  task automatic loadTgt(input int v);
    tgtCount = 18'(v); tgtLoad = 1'b1;
    @(negedge clk); tgtLoad = 1'b0;
  endtask
  task automatic startXfer(input logic [15:0] p, input bit cmd, input bit din);
    progLen = p; cmdPhase = cmd; dirIn = din; xferStart = 1'b1;
    @(negedge clk); xferStart = 1'b0;
  endtask
  task automatic giveChunk(input int n);
    chunkLen = 17'(n); chunkRdy = 1'b1;
    @(negedge clk); chunkRdy = 1'b0;
  endtask
  task automatic doMove(input int n);
    moveBytes = 17'(n); moveStb = 1'b1;
    @(negedge clk); moveStb = 1'b0;
  endtask
  task automatic ackIrq();
    intAck = 1'b1;
    @(negedge clk); intAck = 1'b0;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!finished) begin
      nChecks++; nFails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R12: reset state
    check(xferLeft == 0 && countReg == 0, "R12 counts", int'(xferLeft), 0);
    check(statusReg == 0 && intrReg == 0 && !irq && !xferDone, "R12 flags", int'(statusReg), 0);
    rstN = 1'b1;
    @(negedge clk);

    // Vector walk: R1, R2, R3, R4
    for (int i = 0; i < NV; i++) begin
      loadTgt(V_TGT[i]);
      startXfer(V_PROG[i], V_CMD[i], 1'b1);
      check(int'(xferLeft) == V_EXP[i], "R1/R2/R3 effective length", int'(xferLeft), V_EXP[i]);
      check(countReg == V_PROG[i], "R4 count held", int'(countReg), int'(V_PROG[i]));
    end

    // R6: data-in, target still has data -> immediate completion
    loadTgt(200);
    startXfer(16'd100, 1'b0, 1'b1);
    check(statusReg[4] == 1'b0, "R4 tc cleared", int'(statusReg), 0);
    giveChunk(100);
    doMove(100);
    check(xferDone == 1'b1, "R6 done pulse", int'(xferDone), 1);
    check(statusReg == 8'h90 && intrReg == 8'h10, "R5 status", int'(statusReg), 8'h90);
    check(irq && countReg == 0, "R5 irq and count cleared", int'(countReg), 0);
    check(tgtRemain == 100, "R9 read decrements", int'(tgtRemain), 100);

    // R11: acknowledge
    ackIrq();
    check(!irq && statusReg == 8'h10, "R11 ack", int'(statusReg), 8'h10);

    // R7: data-in, target count reaches zero -> deferred
    loadTgt(100);
    startXfer(16'd100, 1'b0, 1'b1);
    giveChunk(100);
    doMove(100);
    check(!xferDone && !irq && xferLeft == 0, "R7 deferred data-in", int'(irq), 0);
    // R10: zero-size chunk ignored
    giveChunk(0);
    check(!xferDone && !irq, "R10 zero chunk ignored", int'(irq), 0);
    giveChunk(5);
    check(xferDone && irq && intrReg == 8'h10, "R7 completes on chunk", int'(xferDone), 1);
    ackIrq();

    // R7/R9: data-out always defers; remaining count rises to zero
    loadTgt(-60);
    startXfer(16'd0, 1'b0, 1'b0);
    check(xferLeft == 60, "R2 data-out magnitude", int'(xferLeft), 60);
    giveChunk(60);
    doMove(25);
    check(tgtRemain == -35, "R9 write increments", int'(tgtRemain), -35);
    doMove(35);
    check(!xferDone && !irq && tgtRemain == 0, "R7 data-out deferred", int'(tgtRemain), 0);
    @(negedge clk);
    check(!irq, "R7 still waiting", int'(irq), 0);
    giveChunk(8);
    check(xferDone && irq, "R7 data-out completes", int'(xferDone), 1);
    ackIrq();

    // R8 and R10: partial chunk, zero-size move ignored
    loadTgt(500);
    startXfer(16'd40, 1'b0, 1'b1);
    giveChunk(64);
    doMove(0);
    check(xferLeft == 40 && tgtRemain == 500 && !irq, "R10 zero move ignored", int'(xferLeft), 40);
    doMove(40);
    check(xferDone && irq && countReg == 0, "R8 partial chunk completes", int'(xferDone), 1);
    @(negedge clk);
    check(!xferDone, "R5 single-cycle pulse", int'(xferDone), 0);
    ackIrq();

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end
endmodule